// File: doc/BRIEF.md
# Timer Input Capture Unit

This block is a 16-bit free-running counter with one capture channel and two compare channels, reached by a processor over an 8-bit register bus. A rising edge on the selected event input copies the current count into a capture register, sets a flag and, when enabled, raises an interrupt request. The event comes either from an external pin or from a comparator-result input. Both inputs are asynchronous and pass through a synchroniser first. The captured value can also act as the counter's wrap point, which gives a period set by the last capture.

Every 16-bit register is reached as two byte addresses through one shared high-byte holding register. A low-byte read fetches the whole word at once: the low byte goes to the bus and the high byte is parked for the following high-byte read. A high-byte write parks its byte, and the next low-byte write updates all 16 bits in one edge. The request lines are registered. Each one needs its flag, its mask bit and the global enable input.

Address map on `bus_addr`:
- 0x0: control. Bit 0 is the run bit, bit 1 is the source (0 = pin, 1 = comparator), bit 2 is the wrap-at-capture mode.
- 0x1: mask.
- 0x2: flags.
- 0x4/0x5: counter, low/high.
- 0x6/0x7: capture, low/high.
- 0x8/0x9: compare A, low/high.
- 0xA/0xB: compare B, low/high.

Top module: `ictmr_top`

## Requirements
- R1: After reset the control, mask, flag and capture registers read 0x00, the counter is stopped and all four interrupt outputs are low.
- R2: A rising edge of the selected event input, taken through a two-stage synchroniser, loads the capture register with the counter value and sets flag bit 5. With the counter stopped, the captured value equals the stopped count.
- R3: Control bit 1 picks the event source: 0 for `cap_pin`, 1 for `cmp_in`. Edges on the unselected input change neither the capture register nor the flags.
- R4: A read of a low-byte address (even address) returns the low byte and loads the shared holding register with the high byte of the same register. A read of a high-byte address (odd address) returns the holding register. Read data appears on `bus_rdata` the cycle after the read strobe. One holding register serves all 16-bit registers.
- R5: A write to a high-byte address of the counter or a compare register stores the byte in the holding register. A write to the low byte then updates all 16 bits at once. Writes to the capture addresses have no effect.
- R6: The mask register keeps the capture enable in bit 5, compare B in bit 2, compare A in bit 1 and overflow in bit 0. Bits 7, 6, 4 and 3 always read as zero.
- R7: Each interrupt output is high the cycle after its flag bit, its mask bit and `gie` are all one, and low otherwise.
- R8: A flag bit clears when a one is written to its position in the flag register, and writing zero leaves it unchanged. If the bit is set and cleared in the same cycle, it ends up set.
- R9: While running, the counter equal to compare A sets flag bit 1, and equal to compare B sets flag bit 2.
- R10: While running in free mode, the counter wraps from 0xFFFF to 0 and sets flag bit 0.
- R11: When control bit 2 is set, the running counter wraps to 0 in the cycle after it equals the capture value, and each such wrap sets flag bit 0.
- R12: The counter advances only while control bit 0 is set. A bus write to the counter takes precedence over counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| cap_pin | input | 1 | External capture event, asynchronous |
| cmp_in | input | 1 | Comparator-result capture event, asynchronous |
| gie | input | 1 | Global interrupt enable |
| irq_cap | output | 1 | Capture interrupt request |
| irq_cmpa | output | 1 | Compare A interrupt request |
| irq_cmpb | output | 1 | Compare B interrupt request |
| irq_ovf | output | 1 | Overflow/wrap interrupt request |

## Verification
An input edge driven before clock edge k reaches the second synchroniser stage at edge k+1, so the capture register and flag bit 5 change at edge k+2. The bench stops the counter before each capture so that the expected value is exact, and it reads the result only after several idle cycles. Bus read data is registered, so each read task samples `bus_rdata` at the falling edge after the clock edge that saw the strobe. Interrupt outputs trail their flag, mask and `gie` by one edge, and the bench waits two cycles before sampling them. The same-cycle set/clear case is timed by placing the clear write on edge k+2 of a capture.

// File: rtl/ictmr_pkg.sv
package ictmr_pkg;
  // byte addresses of the register bus
  localparam logic [3:0] A_CTRL   = 4'h0;
  localparam logic [3:0] A_MASK   = 4'h1;
  localparam logic [3:0] A_FLAG   = 4'h2;
  localparam logic [3:0] A_CNT_L  = 4'h4;
  localparam logic [3:0] A_CNT_H  = 4'h5;
  localparam logic [3:0] A_CAP_L  = 4'h6;
  localparam logic [3:0] A_CAP_H  = 4'h7;
  localparam logic [3:0] A_CMPA_L = 4'h8;
  localparam logic [3:0] A_CMPA_H = 4'h9;
  localparam logic [3:0] A_CMPB_L = 4'hA;
  localparam logic [3:0] A_CMPB_H = 4'hB;

  // shared bit positions of mask and flag registers
  localparam int B_OVF  = 0;
  localparam int B_CMPA = 1;
  localparam int B_CMPB = 2;
  localparam int B_CAP  = 5;
  localparam logic [7:0] IRQ_BITS = 8'h27;

  // control bits
  localparam int C_RUN = 0;
  localparam int C_SRC = 1;
  localparam int C_TOP = 2;
  localparam int CTRL_W = 3;
endpackage

// File: rtl/ictmr_sync.sv
module ictmr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic level
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/ictmr_evsrc.sv
module ictmr_evsrc #(
  parameter int STAGES = 2,
  parameter int NSRC   = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_in,
  input  logic            src_sel,
  output logic            event_p
);
  localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic [NSRC-1:0] lvl;
  logic            sel_lvl;
  logic            prev_lvl;
  logic [SEL_W-1:0] sel_idx;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ictmr_sync #(.STAGES(STAGES)) u_sync (
      .clk  (clk),
      .rst  (rst),
      .din  (src_in[g]),
      .level(lvl[g])
    );
  end

  assign sel_idx = SEL_W'(src_sel);
  assign sel_lvl = lvl[sel_idx];

  always_ff @(posedge clk) begin
    if (rst) prev_lvl <= 1'b0;
    else     prev_lvl <= sel_lvl;
  end

  assign event_p = sel_lvl & ~prev_lvl;
endmodule

// File: rtl/ictmr_core.sv
module ictmr_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          top_mode,
  input  logic          cap_ev,
  input  logic          wr_cnt,
  input  logic          wr_cmpa,
  input  logic          wr_cmpb,
  input  logic [CW-1:0] wr_val,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cap,
  output logic [CW-1:0] cmpa,
  output logic [CW-1:0] cmpb,
  output logic          ev_ovf,
  output logic          ev_cmpa,
  output logic          ev_cmpb
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic at_top;
  logic counting;

  assign at_top   = top_mode ? (cnt == cap) : (cnt == CNT_MAX);
  assign counting = run & ~wr_cnt;
  assign ev_ovf   = counting & at_top;
  assign ev_cmpa  = counting & (cnt == cmpa);
  assign ev_cmpb  = counting & (cnt == cmpb);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_cnt) begin
      cnt <= wr_val;
    end else if (run) begin
      cnt <= at_top ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         cap <= '0;
    else if (cap_ev) cap <= cnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cmpa <= '0;
      cmpb <= '0;
    end else begin
      if (wr_cmpa) cmpa <= wr_val;
      if (wr_cmpb) cmpb <= wr_val;
    end
  end
endmodule

// File: rtl/ictmr_regs.sv
module ictmr_regs
  import ictmr_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            ev_cap,
  input  logic            ev_cmpa,
  input  logic            ev_cmpb,
  input  logic            ev_ovf,
  input  logic [2*DW-1:0] cnt,
  input  logic [2*DW-1:0] cap,
  input  logic [2*DW-1:0] cmpa,
  input  logic [2*DW-1:0] cmpb,
  output logic            run,
  output logic            src_sel,
  output logic            top_mode,
  output logic [DW-1:0]   mask,
  output logic [DW-1:0]   flags,
  output logic            wr_cnt,
  output logic            wr_cmpa,
  output logic            wr_cmpb,
  output logic [2*DW-1:0] wr_val
);
  localparam int WW = 2 * DW;

  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     hold;
  logic              rd, wr;
  logic              lo_byte;
  logic              word_hit;
  logic [WW-1:0]     word;
  logic [DW-1:0]     set_v, clr_v;
  logic              hold_wr;

  assign rd      = bus_sel & ~bus_we;
  assign wr      = bus_sel &  bus_we;
  assign lo_byte = ~bus_addr[0];

  // selected 16-bit register for the word addresses
  always_comb begin
    word     = '0;
    word_hit = 1'b1;
    case (bus_addr[AW-1:1])
      A_CNT_L[AW-1:1]:  word = cnt;
      A_CAP_L[AW-1:1]:  word = cap;
      A_CMPA_L[AW-1:1]: word = cmpa;
      A_CMPB_L[AW-1:1]: word = cmpb;
      default:          word_hit = 1'b0;
    endcase
  end

  assign wr_val  = {hold, bus_wdata};
  assign wr_cnt  = wr && (bus_addr == A_CNT_L);
  assign wr_cmpa = wr && (bus_addr == A_CMPA_L);
  assign wr_cmpb = wr && (bus_addr == A_CMPB_L);
  assign hold_wr = wr && ((bus_addr == A_CNT_H) || (bus_addr == A_CMPA_H) ||
                          (bus_addr == A_CMPB_H));

  // shared high-byte holding register
  always_ff @(posedge clk) begin
    if (rst)                          hold <= '0;
    else if (hold_wr)                 hold <= bus_wdata;
    else if (rd && word_hit && lo_byte) hold <= word[WW-1:DW];
  end

  // read data path
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      if (word_hit) begin
        bus_rdata <= lo_byte ? word[DW-1:0] : hold;
      end else begin
        case (bus_addr)
          A_CTRL:  bus_rdata <= DW'(ctrl);
          A_MASK:  bus_rdata <= mask;
          A_FLAG:  bus_rdata <= flags;
          default: bus_rdata <= '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
      mask <= '0;
    end else if (wr) begin
      if (bus_addr == A_CTRL) ctrl <= bus_wdata[CTRL_W-1:0];
      if (bus_addr == A_MASK) mask <= bus_wdata & IRQ_BITS;
    end
  end

  assign run      = ctrl[C_RUN];
  assign src_sel  = ctrl[C_SRC];
  assign top_mode = ctrl[C_TOP];

  // flag register: write-one-to-clear, set wins
  always_comb begin
    set_v         = '0;
    set_v[B_CAP]  = ev_cap;
    set_v[B_CMPA] = ev_cmpa;
    set_v[B_CMPB] = ev_cmpb;
    set_v[B_OVF]  = ev_ovf;
    clr_v = (wr && (bus_addr == A_FLAG)) ? (bus_wdata & IRQ_BITS) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr_v) | set_v;
  end
endmodule

// File: rtl/ictmr_top.sv
module ictmr_top
  import ictmr_pkg::*;
#(
  parameter int DW          = 8,
  parameter int AW          = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          cap_pin,
  input  logic          cmp_in,
  input  logic          gie,
  output logic          irq_cap,
  output logic          irq_cmpa,
  output logic          irq_cmpb,
  output logic          irq_ovf
);
  localparam int CW = 2 * DW;

  logic          run, src_sel, top_mode;
  logic [DW-1:0] mask, flags;
  logic          wr_cnt, wr_cmpa, wr_cmpb;
  logic [CW-1:0] wr_val;
  logic [CW-1:0] cnt, cap, cmpa, cmpb;
  logic          ev_cap, ev_cmpa, ev_cmpb, ev_ovf;
  logic [DW-1:0] pend;

  ictmr_evsrc #(.STAGES(SYNC_STAGES), .NSRC(2)) u_evsrc (
    .clk    (clk),
    .rst    (rst),
    .src_in ({cmp_in, cap_pin}),
    .src_sel(src_sel),
    .event_p(ev_cap)
  );

  ictmr_core #(.CW(CW)) u_core (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .top_mode(top_mode),
    .cap_ev  (ev_cap),
    .wr_cnt  (wr_cnt),
    .wr_cmpa (wr_cmpa),
    .wr_cmpb (wr_cmpb),
    .wr_val  (wr_val),
    .cnt     (cnt),
    .cap     (cap),
    .cmpa    (cmpa),
    .cmpb    (cmpb),
    .ev_ovf  (ev_ovf),
    .ev_cmpa (ev_cmpa),
    .ev_cmpb (ev_cmpb)
  );

  ictmr_regs #(.DW(DW), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .bus_sel  (bus_sel),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .ev_cap   (ev_cap),
    .ev_cmpa  (ev_cmpa),
    .ev_cmpb  (ev_cmpb),
    .ev_ovf   (ev_ovf),
    .cnt      (cnt),
    .cap      (cap),
    .cmpa     (cmpa),
    .cmpb     (cmpb),
    .run      (run),
    .src_sel  (src_sel),
    .top_mode (top_mode),
    .mask     (mask),
    .flags    (flags),
    .wr_cnt   (wr_cnt),
    .wr_cmpa  (wr_cmpa),
    .wr_cmpb  (wr_cmpb),
    .wr_val   (wr_val)
  );

  assign pend = flags & mask & {DW{gie}};

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_cap  <= 1'b0;
      irq_cmpa <= 1'b0;
      irq_cmpb <= 1'b0;
      irq_ovf  <= 1'b0;
    end else begin
      irq_cap  <= pend[B_CAP];
      irq_cmpa <= pend[B_CMPA];
      irq_cmpb <= pend[B_CMPB];
      irq_ovf  <= pend[B_OVF];
    end
  end
endmodule

// File: rtl/ictmr_chk.sv
module ictmr_chk #(
  parameter int DW = 8,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_rdata,
  input logic          gie,
  input logic          irq_cap,
  input logic          irq_cmpa,
  input logic          irq_cmpb,
  input logic          irq_ovf,
  input logic          run,
  input logic          top_mode,
  input logic          wr_cnt,
  input logic          ev_cap,
  input logic [DW-1:0] flags,
  input logic [2*DW-1:0] cnt,
  input logic [2*DW-1:0] cap
);
  // unused mask positions never show up on a mask read
  assert_mask_rsvd_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == 4'h1) |=> ((bus_rdata & 8'hD8) == 8'h00));

  // any request needs the global enable one cycle earlier
  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (irq_cap || irq_cmpa || irq_cmpb || irq_ovf) |-> $past(gie));

  // a capture event always leaves its flag set, even against a clear
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    ev_cap |=> flags[5]);

  // the capture register only moves together with its flag
  assert_cap_flag_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(cap) |-> flags[5]);

  // wrap at the captured value in top mode
  assert_top_wrap_R11: assert property (@(posedge clk) disable iff (rst)
    (run && top_mode && !wr_cnt && cnt == cap) |=> (cnt == '0));

  // stopped counter holds its value
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_cnt) |=> $stable(cnt));
endmodule

bind ictmr_top ictmr_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_sel  (bus_sel),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_rdata(bus_rdata),
  .gie      (gie),
  .irq_cap  (irq_cap),
  .irq_cmpa (irq_cmpa),
  .irq_cmpb (irq_cmpb),
  .irq_ovf  (irq_ovf),
  .run      (run),
  .top_mode (top_mode),
  .wr_cnt   (wr_cnt),
  .ev_cap   (ev_cap),
  .flags    (flags),
  .cnt      (cnt),
  .cap      (cap)
);

// File: tb/test_ictmr_top.sv
module test_ictmr_top;
  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  // {value written to mask, value expected on read}
  localparam logic [15:0] MASK_VEC [NVEC] = '{
    16'hFF27, 16'h2020, 16'h0404, 16'hD800, 16'h0303, 16'h0000
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       cap_pin = 1'b0, cmp_in = 1'b0, gie = 1'b0;
  logic       irq_cap, irq_cmpa, irq_cmpb, irq_ovf;
  int         n_chk = 0, n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  ictmr_top i_ictmr_top (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cap_pin(cap_pin), .cmp_in(cmp_in), .gie(gie),
    .irq_cap(irq_cap), .irq_cmpa(irq_cmpa), .irq_cmpb(irq_cmpb), .irq_ovf(irq_ovf)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic brd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd16(input logic [3:0] lo, output logic [15:0] v);
    logic [7:0] l, h;
    brd(lo, l);
    brd(lo + 4'h1, h);
    v = {h, l};
  endtask

  task automatic wr16(input logic [3:0] lo, input logic [15:0] v);
    bwr(lo + 4'h1, v[15:8]);
    bwr(lo, v[7:0]);
  endtask

  task automatic pulse(input bit use_cmp);
    @(negedge clk);
    if (use_cmp) cmp_in = 1'b1; else cap_pin = 1'b1;
    repeat (4) @(negedge clk);
    cmp_in = 1'b0; cap_pin = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0]  b;
    logic [15:0] w;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    brd(4'h0, b); check("R1 ctrl", {8'h0, b}, 16'h0000);
    brd(4'h1, b); check("R1 mask", {8'h0, b}, 16'h0000);
    brd(4'h2, b); check("R1 flags", {8'h0, b}, 16'h0000);
    rd16(4'h6, w); check("R1 capture", w, 16'h0000);
    check("R1 irqs", {12'h0, irq_cap, irq_cmpa, irq_cmpb, irq_ovf}, 16'h0000);

    // R6 mask vectors
    for (int i = 0; i < NVEC; i++) begin
      bwr(4'h1, MASK_VEC[i][15:8]);
      brd(4'h1, b);
      check("R6 mask readback", {8'h0, b}, {8'h0, MASK_VEC[i][7:0]});
    end

    // R5 atomic write, R4 atomic read, R12 hold while stopped
    wr16(4'h4, 16'h1234);
    rd16(4'h4, w); check("R5 counter write", w, 16'h1234);
    repeat (10) @(negedge clk);
    rd16(4'h4, w); check("R12 stopped counter holds", w, 16'h1234);

    // R2 capture of stopped count
    pulse(1'b0);
    rd16(4'h6, w); check("R2 capture value", w, 16'h1234);
    brd(4'h2, b); check("R2 capture flag", {8'h0, b}, 16'h0020);

    // R4 holding register is shared
    wr16(4'h4, 16'hABCD);
    brd(4'h6, b); check("R4 capture low", {8'h0, b}, 16'h0034);
    brd(4'h5, b); check("R4 shared hold", {8'h0, b}, 16'h0012);

    // R5 capture is read-only
    bwr(4'h7, 8'h55); bwr(4'h6, 8'h66);
    rd16(4'h6, w); check("R5 capture read-only", w, 16'h1234);

    // R8 write-one-to-clear
    bwr(4'h2, 8'h00);
    brd(4'h2, b); check("R8 write zero keeps", {8'h0, b}, 16'h0020);
    bwr(4'h2, 8'h20);
    brd(4'h2, b); check("R8 write one clears", {8'h0, b}, 16'h0000);

    // R3 source select
    bwr(4'h0, 8'h02);
    wr16(4'h4, 16'h0777);
    pulse(1'b0);
    rd16(4'h6, w); check("R3 pin ignored cap", w, 16'h1234);
    brd(4'h2, b); check("R3 pin ignored flag", {8'h0, b}, 16'h0000);
    pulse(1'b1);
    rd16(4'h6, w); check("R3 comparator capture", w, 16'h0777);
    bwr(4'h2, 8'h20);
    bwr(4'h0, 8'h00);

    // R8 set wins over same-cycle clear
    @(negedge clk); cap_pin = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 4'h2; bus_wdata = 8'h20;
    @(negedge clk); bus_sel = 1'b0; bus_we = 1'b0;
    repeat (3) @(negedge clk); cap_pin = 1'b0;
    repeat (4) @(negedge clk);
    brd(4'h2, b); check("R8 set wins", {8'h0, b}, 16'h0020);

    // R7 interrupt gating
    bwr(4'h1, 8'h20);
    repeat (2) @(negedge clk);
    check("R7 no gie", {15'h0, irq_cap}, 16'h0000);
    gie = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 request", {15'h0, irq_cap}, 16'h0001);
    bwr(4'h1, 8'h00);
    repeat (2) @(negedge clk);
    check("R7 masked", {15'h0, irq_cap}, 16'h0000);
    gie = 1'b0;
    bwr(4'h2, 8'h27);

    // R9 compare matches
    wr16(4'h8, 16'h0010);
    wr16(4'hA, 16'h8000);
    wr16(4'h4, 16'h0008);
    bwr(4'h2, 8'h27);
    bwr(4'h0, 8'h01);
    repeat (30) @(negedge clk);
    bwr(4'h0, 8'h00);
    brd(4'h2, b); check("R9 compare A only", {8'h0, b}, 16'h0002);
    rd16(4'h4, w); check("R12 counter advanced", {15'h0, w > 16'h0010}, 16'h0001);

    // R10 overflow wrap
    wr16(4'h8, 16'h4000);
    wr16(4'h4, 16'hFFF0);
    bwr(4'h2, 8'h27);
    bwr(4'h0, 8'h01);
    repeat (30) @(negedge clk);
    bwr(4'h0, 8'h00);
    brd(4'h2, b); check("R10 overflow flag", {8'h0, b}, 16'h0001);
    rd16(4'h4, w); check("R10 wrapped low", {15'h0, w < 16'h0040}, 16'h0001);

    // R11 wrap at captured value
    wr16(4'h4, 16'h0005);
    pulse(1'b0);
    rd16(4'h6, w); check("R11 top captured", w, 16'h0005);
    wr16(4'h4, 16'h0000);
    bwr(4'h2, 8'h27);
    bwr(4'h0, 8'h05);
    repeat (40) @(negedge clk);
    bwr(4'h0, 8'h04);
    rd16(4'h4, w); check("R11 count bounded", {15'h0, w <= 16'h0005}, 16'h0001);
    brd(4'h2, b); check("R11 wrap flag", {8'h0, b}, 16'h0001);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule